// File: doc/BRIEF.md
# Eight-Pin Bidirectional I/O Port

This block controls a small bank of general-purpose pins. Two writable registers control the pins: a direction register and a level register. Each pin uses one bit from each register. Together these two bits put the pin in one of four modes:

- MODE_FLOAT: floating input.
- MODE_PULL: input with the weak pull-up switched on.
- MODE_LOW: driven low.
- MODE_HIGH: driven high.

The level bit therefore does one of two jobs. On an output pin it sets the level that is driven. On an input pin it chooses between pull-up and floating.

A third address reads the sensed pad levels through a two-flop synchronizer, whatever mode each pin is in. A per-pin override hook lets a neighbouring function take over a pin's driver. The hook does not change any register.

The per-pin mode decode is an enumerated selector over the four modes named above, written with a unique case. A mode changes only when software writes a new direction or level bit; it moves straight from any mode to any other mode. Reset forces MODE_FLOAT on every pin.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction and level registers read 0x00, and every pin has pad_oe=0, pad_out=0 and pad_pu=0.
- R2: A pin with direction 0 and level 0 is a floating input: pad_oe=0 and pad_pu=0.
- R3: A pin with direction 0 and level 1 is an input with pull-up: pad_oe=0 and pad_pu=1. The pull-up is never on for a pin that is driving.
- R4: A pin with direction 1 drives: pad_oe=1, pad_out equals its level bit, and pad_pu=0.
- R5: A write with bus_wr=1 and bus_en=1 stores bus_wdata. Address 0 is the direction register and address 1 is the level register. Both read back on bus_rdata, and the pins follow after the clock edge that stores the write.
- R6: Address 2 returns pad_in delayed by exactly two clock edges, whatever the pin modes are.
- R7: A write to address 2 or address 3 changes neither register. Address 3 reads 0x00.
- R8: When alt_en[i]=1, pad_oe[i] follows alt_oe[i], pad_out[i] follows alt_out[i] and pad_pu[i]=0. The registers are unchanged.
- R9: pad_out[i] is 0 whenever pad_oe[i] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 direction, 1 level, 2 input |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Sensed pad levels |
| pad_oe | output | 8 | Pad driver enable |
| pad_out | output | 8 | Pad driven level |
| pad_pu | output | 8 | Weak pull-up enable |
| alt_en | input | 8 | Per-pin override select |
| alt_oe | input | 8 | Override driver enable |
| alt_out | input | 8 | Override driven level |

## Verification
Two functions can fall in the same cycle: a register write that turns pins into outputs, and a change on the pad inputs. The bench changes pad_in in the same cycle as it writes the direction register. It then judges that the driver outputs switch after one edge, while the input register still shows the old pad value and only shows the new one after the second edge. A second collision pairs the override hook with a pull-up mode on the same pin. Here the override must win, and the register contents must survive.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_DIR = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LVL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_IN  = 2'd2;

    typedef enum logic [1:0] {
        MODE_FLOAT = 2'b00,
        MODE_PULL  = 2'b01,
        MODE_LOW   = 2'b10,
        MODE_HIGH  = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  in_sync,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  lvl_q
);
    logic wr_dir, wr_lvl;

    assign wr_dir = bus_en && bus_wr && (bus_addr == ADDR_DIR);
    assign wr_lvl = bus_en && bus_wr && (bus_addr == ADDR_LVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else begin
            if (wr_dir) dir_q <= bus_wdata;
            if (wr_lvl) lvl_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_DIR: bus_rdata = dir_q;
            ADDR_LVL: bus_rdata = lvl_q;
            ADDR_IN:  bus_rdata = in_sync;
            default:  bus_rdata = '0;
        endcase
    end

    // R7: writes to the input or spare address leave both registers unchanged
    a_r7_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr[1]) |=> ($stable(dir_q) && $stable(lvl_q)));

    // R5: a direction write is visible at the read port on the next cycle
    a_r5_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == ADDR_DIR) |=> (dir_q == $past(bus_wdata)));
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_pkg::*;
(
    input  logic dir_bit,
    input  logic lvl_bit,
    input  logic alt_en,
    input  logic alt_oe,
    input  logic alt_out,
    output logic oe,
    output logic out,
    output logic pu
);
    pin_mode_e mode;
    logic      reg_oe, reg_out, reg_pu;

    assign mode = pin_mode_e'({dir_bit, lvl_bit});

    always_comb begin
        unique case (mode)
            MODE_FLOAT: begin reg_oe = 1'b0; reg_out = 1'b0; reg_pu = 1'b0; end
            MODE_PULL:  begin reg_oe = 1'b0; reg_out = 1'b0; reg_pu = 1'b1; end
            MODE_LOW:   begin reg_oe = 1'b1; reg_out = 1'b0; reg_pu = 1'b0; end
            MODE_HIGH:  begin reg_oe = 1'b1; reg_out = 1'b1; reg_pu = 1'b0; end
            default:    begin reg_oe = 1'b0; reg_out = 1'b0; reg_pu = 1'b0; end
        endcase
    end

    always_comb begin
        if (alt_en) begin
            oe  = alt_oe;
            out = alt_oe & alt_out;
            pu  = 1'b0;
        end else begin
            oe  = reg_oe;
            out = reg_out;
            pu  = reg_pu;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pu,
    input  logic [NPINS-1:0]  alt_en,
    input  logic [NPINS-1:0]  alt_oe,
    input  logic [NPINS-1:0]  alt_out
);
    logic [NPINS-1:0] dir_q, lvl_q, in_sync;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (in_sync)
    );

    gpio_regs #(.WIDTH(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .in_sync  (in_sync),
        .bus_rdata(bus_rdata),
        .dir_q    (dir_q),
        .lvl_q    (lvl_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_ctl u_pin (
            .dir_bit(dir_q[i]),
            .lvl_bit(lvl_q[i]),
            .alt_en (alt_en[i]),
            .alt_oe (alt_oe[i]),
            .alt_out(alt_out[i]),
            .oe     (pad_oe[i]),
            .out    (pad_out[i]),
            .pu     (pad_pu[i])
        );

        // R3: pull-up never enabled on a driving pin
        a_r3_pull_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
            pad_pu[i] |-> !pad_oe[i]);

        // R9: output level quiet while not driving
        a_r9_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_oe[i] |-> !pad_out[i]);

        // R8: override forces pull-up off
        a_r8_alt_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
            alt_en[i] |-> !pad_pu[i]);
    end

    // R1: first cycle after reset leaves every pin floating
    a_r1_reset_float: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && alt_en == '0) |-> (pad_oe == '0 && pad_pu == '0));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic [7:0] pad_in = 8'h00, pad_oe, pad_out, pad_pu;
    logic [7:0] alt_en = 8'h00, alt_oe = 8'h00, alt_out = 8'h00;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out)
    );

    // {dir, lvl, exp_oe, exp_out, exp_pu}
    localparam logic [39:0] VEC [6] = '{
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF},
        {8'hFF, 8'hA5, 8'hFF, 8'hA5, 8'h00},
        {8'hF0, 8'hCC, 8'hF0, 8'hC0, 8'h0C},
        {8'h0F, 8'h3C, 8'h0F, 8'h0C, 8'h30},
        {8'h5A, 8'h96, 8'h5A, 8'h12, 8'h84}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pu", pad_pu, 8'h00);
        rst_n = 1'b1;
        bus_read(2'd0, rd); check("R1 dir", rd, 8'h00);
        bus_read(2'd1, rd); check("R1 lvl", rd, 8'h00);
        check("R1 out", pad_out, 8'h00);

        // R2 R3 R4 R5 R9: table of modes
        for (int v = 0; v < 6; v++) begin
            bus_write(2'd0, VEC[v][39:32]);
            bus_write(2'd1, VEC[v][31:24]);
            #1;
            check("R2/R4 oe", pad_oe, VEC[v][23:16]);
            check("R4/R9 out", pad_out, VEC[v][15:8]);
            check("R3 pu", pad_pu, VEC[v][7:0]);
            bus_read(2'd0, rd); check("R5 dir", rd, VEC[v][39:32]);
            bus_read(2'd1, rd); check("R5 lvl", rd, VEC[v][31:24]);
        end

        // R6: two-edge latency, independent of mode; collision with dir write
        @(negedge clk);
        pad_in = 8'h69;
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; bus_addr = 2'd2;
        #1;
        check("R6 one edge", bus_rdata, 8'h00);
        check("R4 oe after write", pad_oe, 8'hFF);
        @(negedge clk); #1;
        check("R6 two edges", bus_rdata, 8'h69);

        // R7: writes to input / spare address ignored
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h00);
        bus_read(2'd0, rd); check("R7 dir kept", rd, 8'hFF);
        bus_read(2'd1, rd); check("R7 lvl kept", rd, 8'h96);
        bus_read(2'd2, rd); check("R7 in kept", rd, 8'h69);
        bus_read(2'd3, rd); check("R7 spare zero", rd, 8'h00);

        // R8: override on a pull-up pin
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h01);
        @(negedge clk);
        alt_en = 8'h01; alt_oe = 8'h01; alt_out = 8'h01;
        #1;
        check("R8 oe", pad_oe, 8'h01);
        check("R8 out", pad_out, 8'h01);
        check("R8 pu", pad_pu, 8'h00);
        bus_read(2'd1, rd); check("R8 lvl kept", rd, 8'h01);
        @(negedge clk);
        alt_en = 8'h00; alt_oe = 8'h00; alt_out = 8'h00;
        #1; check("R3 pull back", pad_pu, 8'h01);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(2'd1, rd); check("R1 lvl after reset", rd, 8'h00);
        check("R1 pu after reset", pad_pu, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule